// File: doc/BRIEF.md
# Serial Command Dispatcher for a Sample Capture Engine

This block sits between a byte-wide UART and a sample capture engine with its sample memory. It reads single ASCII command letters from the receive stream and acts on them. It sets a depth code and a clock-rate code and loads a trigger pattern. It can start a capture and wait for it to finish. It returns stored samples either as raw bytes or as readable hexadecimal text, and it can fill the memory with a predictable pseudo-random pattern for board testing. The bit-level UART is not part of this block: bytes arrive and leave as valid/ready streams. The host link is expected to run at 19200 bps.

The depth code sets how much memory each transfer covers: the span is `BASE_WORDS << depth_code` bytes, starting at address 0. The capture engine is held in reset by a hold line. Only a capture command releases it. The engine reports the end of a capture on a done input.

Top module: `serial_cmd_dispatcher`

## Requirements
- R1: After reset the block is idle. It accepts input (rx_ready=1), tx_valid=0, cap_hold=1, mem_we=0 and mem_rd=0. depth_code, rate_code, trig_value and trig_edge are all 0.
- R2: Byte 0x73 ('s') followed by a digit byte 0x30..0x37 sets depth_code to the digit minus 0x30.
- R3: Byte 0x63 ('c') followed by a digit byte 0x30..0x37 sets rate_code to the digit minus 0x30.
- R4: A follow-up byte outside 0x30..0x37 after 's' or 'c', or any byte in idle that is not one of s, c, l, t, r, d, w, leaves every output register unchanged and returns the block to idle, ready for the next command.
- R5: Byte 0x6C ('l') is followed by a value byte and then a mode byte. trig_value takes the value byte and trig_edge takes bit 0 of the mode byte. Both update together when the mode byte is accepted, and not before.
- R6: After byte 0x74 ('t') is accepted, cap_hold is 0 from the next cycle on. It stays 0 until cap_done is sampled high, and it is 1 again in the following cycle.
- R7: The commands r, d and w each cover addresses 0 up to (BASE_WORDS << depth_code) - 1 in ascending order and touch no other address. mem_we and mem_rd are never high together.
- R8: Byte 0x72 ('r') sends each memory byte once, unchanged, in address order. The memory returns read data one cycle after mem_rd.
- R9: Byte 0x64 ('d') sends three characters per memory byte: the high nibble and then the low nibble as uppercase ASCII hexadecimal (0-9, A-F), then a space (0x20).
- R10: Byte 0x77 ('w') writes one byte per cycle. The byte written is the low byte of a 16-bit LFSR that shifts right and XORs in 0xB400 when the bit shifted out is 1. The LFSR is restarted from seed 0xACE1 by each 'w' and advances after each write.
- R11: While tx_valid is high and tx_ready is low, tx_data holds its value. No receive byte is accepted (rx_ready=0) while a capture, fill, read or dump is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Block accepts a received byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte is present |
| tx_ready | input | 1 | Transmitter takes the byte |
| depth_code | output | CODE_W | Capture depth code |
| rate_code | output | CODE_W | Sample clock-rate code |
| trig_value | output | 8 | Trigger pattern |
| trig_edge | output | 1 | Trigger on edge (1) or level (0) |
| cap_hold | output | 1 | Holds the capture engine in reset |
| cap_done | input | 1 | Capture engine has finished |
| mem_addr | output | ADDR_W | Sample memory address |
| mem_rd | output | 1 | Memory read request |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_rd |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |

## Verification
A state machine that has slipped into the wrong state shows up at the ports within one cycle of the next received byte. A bad argument state alters depth_code, rate_code or the trigger registers where nothing should change. A stuck transfer leaves rx_ready low, so the next command is never accepted. An address counter or span that is off by one shows up as a missing or extra transmitted byte, or as a write beyond the span. This is seen as soon as the transfer ends. A shifted LFSR state or a wrong nibble order corrupts the first byte written or sent, so a single short transfer exposes it.

// File: rtl/cmd_disp_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and command byte values for the
// serial command dispatcher. Assumes 8-bit ASCII command bytes.
package cmd_disp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARG,
        ST_TRG_VAL,
        ST_TRG_MODE,
        ST_CAPTURE,
        ST_FILL,
        ST_RD_REQ,
        ST_RD_LAT,
        ST_SEND
    } disp_state_t;

    localparam logic [7:0] CMD_DEPTH = 8'h73;
    localparam logic [7:0] CMD_RATE  = 8'h63;
    localparam logic [7:0] CMD_TRIG  = 8'h6C;
    localparam logic [7:0] CMD_RUN   = 8'h74;
    localparam logic [7:0] CMD_RAW   = 8'h72;
    localparam logic [7:0] CMD_HEX   = 8'h64;
    localparam logic [7:0] CMD_FILL  = 8'h77;
    localparam logic [7:0] CHR_ZERO  = 8'h30;
    localparam logic [7:0] CHR_SPACE = 8'h20;

endpackage

// File: rtl/cmd_fill_lfsr.sv
`timescale 1ns/1ps
// Module: cmd_fill_lfsr
// Galois LFSR that shifts right and XORs TAPS in when the bit shifted
// out is 1. The default taps give a maximal-length 16-bit sequence.
// Assumes SEED is non-zero. Restart has priority over step.
module cmd_fill_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] next_value;

    // Next state of the register
    always_comb begin
        next_value = value >> 1;
        if (value[0]) next_value = next_value ^ WIDTH'(TAPS);
    end

    // State register: load the seed on reset or restart, else advance on step
    always_ff @(posedge clk) begin
        if (!rst_n || restart) value <= WIDTH'(SEED);
        else if (step)         value <= next_value;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0); // R10

endmodule

// File: rtl/cmd_hex_ascii.sv
`timescale 1ns/1ps
// Module: cmd_hex_ascii
// Turns a 4-bit nibble into its uppercase ASCII hexadecimal character.
// Purely combinational.
module cmd_hex_ascii (
    input  logic [3:0] nib,
    output logic [7:0] ch
);

    // Digits map from '0' upward, letters from 'A' upward
    always_comb begin
        if (nib < 4'd10) ch = 8'h30 + {4'h0, nib};
        else             ch = 8'h37 + {4'h0, nib};
    end

endmodule

// File: rtl/serial_cmd_dispatcher.sv
`timescale 1ns/1ps
// Module: serial_cmd_dispatcher
// Decodes single-letter commands from a receive byte stream. It sets the
// depth and clock-rate codes, loads the trigger pattern, runs a capture
// handshake, fills memory with an LFSR pattern and streams memory back
// as raw bytes or hex text.
// Assumes: the memory returns read data one cycle after mem_rd, and a
// transfer spans BASE_WORDS << depth_code bytes starting at address 0.
module serial_cmd_dispatcher
    import cmd_disp_pkg::*;
#(
    parameter int BASE_WORDS = 16,
    parameter int CODE_W     = 3,
    localparam int ADDR_W    = $clog2(BASE_WORDS) + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CODE_W-1:0] depth_code,
    output logic [CODE_W-1:0] rate_code,
    output logic [7:0]        trig_value,
    output logic              trig_edge,
    output logic              cap_hold,
    input  logic              cap_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata
);

    localparam logic [7:0] DIGIT_HI = 8'(48 + (1 << CODE_W) - 1);

    disp_state_t       state;
    logic              arg_rate;
    logic              hex_mode;
    logic [1:0]        char_idx;
    logic [7:0]        data_q;
    logic [7:0]        trig_tmp;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W:0]   span_cnt;
    logic [ADDR_W-1:0] span_last;
    logic              rx_fire;
    logic              tx_fire;
    logic              at_last;
    logic              digit_ok;
    logic              char_last;
    logic [15:0]       lfsr_value;
    logic [3:0]        nib_sel;
    logic [7:0]        nib_char;

    // Handshake and span decode
    always_comb begin
        rx_fire   = rx_valid && rx_ready;
        tx_fire   = tx_valid && tx_ready;
        span_cnt  = (ADDR_W + 1)'(BASE_WORDS) << depth_code;
        span_last = ADDR_W'(span_cnt - 1'b1);
        at_last   = addr_q == span_last;
        digit_ok  = (rx_data >= CHR_ZERO) && (rx_data <= DIGIT_HI);
        char_last = !hex_mode || (char_idx == 2'd2);
    end

    // Command sequencer and its registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            arg_rate   <= 1'b0;
            hex_mode   <= 1'b0;
            char_idx   <= 2'd0;
            data_q     <= 8'h00;
            trig_tmp   <= 8'h00;
            addr_q     <= '0;
            depth_code <= '0;
            rate_code  <= '0;
            trig_value <= 8'h00;
            trig_edge  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (rx_fire) begin
                    addr_q <= '0;
                    case (rx_data)
                        CMD_DEPTH: begin arg_rate <= 1'b0; state <= ST_ARG; end
                        CMD_RATE:  begin arg_rate <= 1'b1; state <= ST_ARG; end
                        CMD_TRIG:  state <= ST_TRG_VAL;
                        CMD_RUN:   state <= ST_CAPTURE;
                        CMD_RAW:   begin hex_mode <= 1'b0; state <= ST_RD_REQ; end
                        CMD_HEX:   begin hex_mode <= 1'b1; state <= ST_RD_REQ; end
                        CMD_FILL:  state <= ST_FILL;
                        default:   state <= ST_IDLE;
                    endcase
                end
                ST_ARG: if (rx_fire) begin
                    if (digit_ok && arg_rate)  rate_code  <= CODE_W'(rx_data - CHR_ZERO);
                    if (digit_ok && !arg_rate) depth_code <= CODE_W'(rx_data - CHR_ZERO);
                    state <= ST_IDLE;
                end
                ST_TRG_VAL: if (rx_fire) begin
                    trig_tmp <= rx_data;
                    state    <= ST_TRG_MODE;
                end
                ST_TRG_MODE: if (rx_fire) begin
                    trig_value <= trig_tmp;
                    trig_edge  <= rx_data[0];
                    state      <= ST_IDLE;
                end
                ST_CAPTURE: if (cap_done) state <= ST_IDLE;
                ST_FILL: begin
                    addr_q <= addr_q + 1'b1;
                    if (at_last) state <= ST_IDLE;
                end
                ST_RD_REQ: state <= ST_RD_LAT;
                ST_RD_LAT: begin
                    data_q   <= mem_rdata;
                    char_idx <= 2'd0;
                    state    <= ST_SEND;
                end
                ST_SEND: if (tx_fire) begin
                    if (!char_last) begin
                        char_idx <= char_idx + 1'b1;
                    end else if (at_last) begin
                        state <= ST_IDLE;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                        state  <= ST_RD_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    cmd_fill_lfsr #(
        .WIDTH(16),
        .TAPS (16'hB400),
        .SEED (16'hACE1)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(state == ST_IDLE && rx_fire && rx_data == CMD_FILL),
        .step   (state == ST_FILL),
        .value  (lfsr_value)
    );

    // Nibble selection for the hex dump
    always_comb nib_sel = (char_idx == 2'd0) ? data_q[7:4] : data_q[3:0];

    cmd_hex_ascii u_hex (
        .nib(nib_sel),
        .ch (nib_char)
    );

    // Port outputs decoded from the sequencer state
    always_comb begin
        rx_ready  = (state == ST_IDLE) || (state == ST_ARG) ||
                    (state == ST_TRG_VAL) || (state == ST_TRG_MODE);
        tx_valid  = state == ST_SEND;
        mem_rd    = state == ST_RD_REQ;
        mem_we    = state == ST_FILL;
        mem_addr  = addr_q;
        mem_wdata = lfsr_value[7:0];
        cap_hold  = state != ST_CAPTURE;
        if (!hex_mode)              tx_data = data_q;
        else if (char_idx == 2'd2)  tx_data = CHR_SPACE;
        else                        tx_data = nib_char;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_rd || tx_valid || !cap_hold) |-> !rx_ready); // R11
    AST_CODES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_fire && state == ST_ARG) |=> $stable(depth_code) && $stable(rate_code)); // R4
    AST_TRIG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trig_value) |-> $past(rx_fire && state == ST_TRG_MODE)); // R5
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_hold) |-> $past(rx_fire && rx_data == CMD_RUN)); // R6
    AST_DONE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_hold && cap_done |=> cap_hold); // R6
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_rd)); // R7
    AST_ADDR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_rd) |-> mem_addr <= span_last); // R7

endmodule

// File: tb/serial_cmd_dispatcher_bench.sv
`timescale 1ns/1ps
// Bench for serial_cmd_dispatcher: directed corner cases plus seeded
// random command streams, checked against models held in the bench.
module serial_cmd_dispatcher_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_WORDS = 16;
    localparam int CODE_W     = 3;
    localparam int ADDR_W     = 11;
    localparam int MEM_SIZE   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_valid = 1'b0;
    logic              rx_ready;
    logic [7:0]        tx_data;
    logic              tx_valid;
    logic              tx_ready = 1'b1;
    logic [CODE_W-1:0] depth_code;
    logic [CODE_W-1:0] rate_code;
    logic [7:0]        trig_value;
    logic              trig_edge;
    logic              cap_hold;
    logic              cap_done = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [7:0]        mem_rdata = 8'h00;
    logic              mem_we;
    logic [7:0]        mem_wdata;

    int   checks = 0;
    int   errors = 0;
    int   stall_err = 0;
    bit   rand_ready = 1'b0;
    bit   stall_pending = 1'b0;
    logic [7:0] stall_data = 8'h00;
    logic [7:0] mem [MEM_SIZE];
    logic [7:0] txq [$];

    serial_cmd_dispatcher #(.BASE_WORDS(BASE_WORDS), .CODE_W(CODE_W)) u_serial_cmd_dispatcher (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .depth_code(depth_code), .rate_code(rate_code),
        .trig_value(trig_value), .trig_edge(trig_edge), .cap_hold(cap_hold),
        .cap_done(cap_done), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Sample memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Transmit sink: picks tx_ready, records handshakes, watches stalls
    always @(negedge clk) begin
        if (stall_pending && !(tx_valid && tx_data == stall_data)) stall_err++;
        tx_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
        stall_pending = tx_valid && !tx_ready;
        stall_data = tx_data;
        if (tx_valid && tx_ready) txq.push_back(tx_data);
    end

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return (v >> 1) ^ (v[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [7:0] hex_of(input logic [3:0] n);
        return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic run_read(input logic [7:0] cmd, input int depth, input string tag);
        int n;
        int bad;
        logic [7:0] exp_q [$];
        n = BASE_WORDS << depth;
        for (int i = 0; i < n; i++) begin
            if (cmd == 8'h64) begin
                exp_q.push_back(hex_of(mem[i][7:4]));
                exp_q.push_back(hex_of(mem[i][3:0]));
                exp_q.push_back(8'h20);
            end else begin
                exp_q.push_back(mem[i]);
            end
        end
        txq.delete();
        send_byte(cmd);
        wait_idle();
        repeat (2) @(negedge clk);
        check(txq.size() == exp_q.size(), {tag, " length"}, txq.size(), exp_q.size());
        bad = 0;
        for (int i = 0; i < exp_q.size() && i < txq.size(); i++)
            if (txq[i] !== exp_q[i]) begin
                if (bad == 0) $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, i, txq[i], exp_q[i]);
                bad++;
            end
        check(bad == 0, {tag, " content"}, bad, 0);
    endtask

    task automatic run_fill(input int depth);
        int n;
        int bad;
        logic [15:0] v;
        logic [7:0] beyond;
        n = BASE_WORDS << depth;
        beyond = ~mem[n];
        mem[n] = beyond;
        send_byte(8'h77);
        wait_idle();
        @(negedge clk);
        v = 16'hACE1;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (mem[i] !== v[7:0]) bad++;
            v = lfsr_next(v);
        end
        check(bad == 0, "R10 fill pattern", bad, 0);
        check(mem[0] == 8'hE1, "R10 restart from seed", mem[0], 8'hE1);
        check(mem[n] == beyond, "R7 fill stops at span end", mem[n], beyond);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CODE_W-1:0] m_depth;
        logic [CODE_W-1:0] m_rate;
        logic [7:0]        m_tval;
        logic              m_tedge;
        int                blocked;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_SIZE; i++) mem[i] = 8'($urandom);

        repeat (5) @(negedge clk);
        check(rx_ready == 1'b1 && tx_valid == 1'b0, "R1 reset handshake", {rx_ready, tx_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_ready == 1'b1 && tx_valid == 1'b0, "R1 idle handshake", {rx_ready, tx_valid}, 2'b10);
        check(cap_hold == 1'b1 && !mem_we && !mem_rd, "R1 hold and memory idle", {cap_hold, mem_we, mem_rd}, 3'b100);
        check(depth_code == 0 && rate_code == 0, "R1 codes zero", {depth_code, rate_code}, 0);
        check(trig_value == 0 && trig_edge == 0, "R1 trigger zero", {trig_value, trig_edge}, 0);

        send_byte(8'h73); send_byte(8'h35);
        check(depth_code == 3'd5, "R2 depth digit 5", depth_code, 5);
        send_byte(8'h63); send_byte(8'h37);
        check(rate_code == 3'd7, "R3 rate digit 7", rate_code, 7);
        send_byte(8'h73); send_byte(8'h38);
        check(depth_code == 3'd5, "R4 depth digit 8 ignored", depth_code, 5);
        send_byte(8'h63); send_byte(8'h2F);
        check(rate_code == 3'd7, "R4 rate byte below 0 ignored", rate_code, 7);
        send_byte(8'h78);
        check(rx_ready && depth_code == 5 && rate_code == 7 && cap_hold, "R4 unknown letter ignored",
              {rx_ready, depth_code, rate_code}, {1'b1, 3'd5, 3'd7});
        send_byte(8'h73); send_byte(8'h30);
        check(depth_code == 3'd0, "R2 depth digit 0 after unknown", depth_code, 0);

        send_byte(8'h6C); send_byte(8'hA5);
        check(trig_value == 8'h00 && trig_edge == 1'b0, "R5 no update before mode byte", trig_value, 0);
        send_byte(8'h03);
        check(trig_value == 8'hA5 && trig_edge == 1'b1, "R5 trigger loaded", {trig_value, trig_edge}, {8'hA5, 1'b1});

        m_depth = 0; m_rate = 7; m_tval = 8'hA5; m_tedge = 1'b1;
        for (int k = 0; k < 40; k++) begin
            int sel;
            int dg;
            logic [7:0] b0;
            logic [7:0] b1;
            sel = $urandom % 4;
            if (sel < 2) begin
                dg = $urandom % 11;
                send_byte(sel == 0 ? 8'h73 : 8'h63);
                send_byte(8'h2F + 8'(dg));
                if (dg >= 1 && dg <= 8) begin
                    if (sel == 0) m_depth = CODE_W'(dg - 1);
                    else          m_rate  = CODE_W'(dg - 1);
                end
                check(depth_code == m_depth && rate_code == m_rate, "R2 R3 R4 random code",
                      {depth_code, rate_code}, {m_depth, m_rate});
            end else if (sel == 2) begin
                b0 = 8'($urandom); b1 = 8'($urandom);
                send_byte(8'h6C); send_byte(b0); send_byte(b1);
                m_tval = b0; m_tedge = b1[0];
                check(trig_value == m_tval && trig_edge == m_tedge, "R5 random trigger",
                      {trig_value, trig_edge}, {m_tval, m_tedge});
            end else begin
                b0 = 8'h41 + 8'($urandom % 26);
                send_byte(b0);
                check(depth_code == m_depth && rate_code == m_rate && trig_value == m_tval && rx_ready,
                      "R4 random unknown byte", {depth_code, rate_code}, {m_depth, m_rate});
            end
        end

        send_byte(8'h73); send_byte(8'h30);
        rand_ready = 1'b1;
        run_fill(0);
        run_read(8'h72, 0, "R8 raw read depth 0");
        for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
        send_byte(8'h73); send_byte(8'h32);
        run_read(8'h72, 2, "R7 raw read depth 2");
        run_fill(2);
        send_byte(8'h73); send_byte(8'h30);
        mem[0] = 8'hAF; mem[1] = 8'h09; mem[2] = 8'h5C;
        run_read(8'h64, 0, "R9 hex dump");
        rand_ready = 1'b0;
        check(stall_err == 0, "R11 tx data held during stall", stall_err, 0);

        send_byte(8'h74);
        check(cap_hold == 1'b0 && rx_ready == 1'b0, "R6 hold released", {cap_hold, rx_ready}, 2'b00);
        rx_data = 8'h73; rx_valid = 1'b1;
        blocked = 0;
        repeat (6) begin
            @(negedge clk);
            if (rx_ready || cap_hold) blocked++;
        end
        rx_valid = 1'b0;
        check(blocked == 0, "R11 input blocked during capture", blocked, 0);
        cap_done = 1'b1;
        @(negedge clk);
        cap_done = 1'b0;
        check(cap_hold == 1'b1 && rx_ready == 1'b1, "R6 hold back after done", {cap_hold, rx_ready}, 2'b11);
        send_byte(8'h63); send_byte(8'h33);
        check(rate_code == 3'd3 && depth_code == 3'd0, "R3 command after capture", {depth_code, rate_code}, 3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule